// File: doc/BRIEF.md
# Mode-Selectable SPI Drive and Register Slave

This block is the serial side of an eight-channel output controller. An SPI host clocks frames in and out while chip select is low. Two mode-select pins pick one of four frame layouts. In the two drive layouts, every frame carries a new value for the eight-bit drive register. In the two register layouts, every frame carries an address, a read/write flag and a data byte for a small register file. One layout of each kind adds a 5-bit checksum. The slave returns a collective diagnosis byte, three supply and communication status bits, the checksum over those status bits, and the register value that was read.

The SPI pins are oversampled in the system clock domain through synchronizers. A frame is acted on only when chip select rises. The bit count must fit the layout that was latched when chip select fell, and the checksum, where the layout has one, must match. A frame whose checksum fails is thrown away and pulls an active-low error flag. The drive layouts pass extra bits straight through, so several slaves can be chained on one select line.

Top module: `spi_drive_slave`

## Requirements
- R1: After synchronous reset, `drive_q` is 0x00, `crc_err_n` is 1 and `sdo_oe` is 0.
- R2: `sdo_oe` is 1 while a frame is in progress (chip select low) and returns to 0 within four clocks after `cs_n` goes high. `sdo` changes only after SCLK falling edges or at the start of a frame, never after a rising edge.
- R3: The mode is {ms1,ms0}. In mode 0 (00) a frame is 8 bits, MSB first. The received byte becomes `drive_q`, and `sdo` returns `diag_in` MSB first.
- R4: In the drive modes (0 and 1), a frame whose bit count is a nonzero multiple of the frame length is accepted, and the last frame-length bits are used. After the first frame length, `sdo` repeats the `sdi` bits that were received one frame length earlier.
- R5: In mode 1 (01) a frame is 16 bits: the drive byte, three zero bits, then checksum bits 4..0. The slave sends {uv,mv,cf}, then a checksum over those three bits followed by `diag_in`, then `diag_in`. The checksum is a CRC with polynomial x^5+x^2+1 and initial value 11111, shifted MSB first over the 11 bits that precede it in the word.
- R6: In modes 1 and 3, a frame whose checksum does not match is dropped, with no drive or register write, and `crc_err_n` goes to 0. The next accepted frame with a good checksum, or any accepted frame of mode 0 or 2, sets it back to 1.
- R7: In mode 2 (10) a frame is 16 bits: address bits 6..0, a read/write bit (1 = write), then a data byte. Address 0 is the drive register, and addresses 1..NREG-1 are storage registers. The slave sends 0x00 and then either the read value (for a read) or `diag_in` (for a write).
- R8: In mode 3 (11) a frame is 24 bits: address, read/write bit, data byte (zeros for a read), three zero bits and a checksum over the preceding 19 bits. The slave sends {uv,mv,cf} with the R5 status checksum, then the read value (0x00 on a write), then `diag_in`.
- R9: A frame is ignored when its bit count does not fit the mode: a count that is not a multiple of the frame length, or, in modes 2 and 3, more than one frame length.
- R10: The mode is taken from the pins when chip select falls. A pin change during the frame has no effect on that frame.
- R11: A write to an address at or above NREG changes nothing, and a read from such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms0 | input | 1 | Mode select, low bit |
| ms1 | input | 1 | Mode select, high bit |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock, idles low |
| sdi | input | 1 | SPI serial data in |
| sdo | output | 1 | SPI serial data out, valid while sdo_oe is 1 |
| sdo_oe | output | 1 | Enable for the tri-state driver of the SDO pad |
| diag_in | input | 8 | Collective diagnosis byte, one bit per channel |
| uv_in | input | 1 | Supply undervoltage status |
| mv_in | input | 1 | Supply missing status |
| cf_in | input | 1 | Communication fault status |
| drive_q | output | 8 | Drive register, one bit per output channel |
| crc_err_n | output | 1 | Checksum error flag, active low |

## Verification
In the register modes, the read lookup and the outgoing shift fall close together. The slave has to fetch the addressed value and write it into the transmit word between the eighth rising SCLK edge and the next falling edge, while the shift register is also holding the received address. Random register frames read back addresses just written, including address 0, which holds the drive value. The bench compares the second (mode 2) or middle (mode 3) returned byte with its own register model. A daisy-chained drive frame also makes pass-through data and a frame commit meet at the same rising edge of chip select, and the bench judges both the returned bits and the final drive value.

// File: rtl/spi_drv_pkg.sv
package spi_drv_pkg;

  localparam int FRAME_MAX = 24;
  localparam int LEN_W     = 5;
  localparam int CRC_W     = 5;

  typedef enum logic [1:0] {
    M_DRV8  = 2'd0,
    M_DRV16 = 2'd1,
    M_REG16 = 2'd2,
    M_REG24 = 2'd3
  } mode_e;

  function automatic logic [LEN_W-1:0] frame_bits(input mode_e m);
    case (m)
      M_DRV8:  return LEN_W'(8);
      M_REG24: return LEN_W'(24);
      default: return LEN_W'(16);
    endcase
  endfunction

  // serial CRC, polynomial x^5+x^2+1, preset all ones, MSB first over d[n-1:0]
  function automatic logic [CRC_W-1:0] crc5_calc(input logic [FRAME_MAX-1:0] d, input int n);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '1;
    for (int i = FRAME_MAX - 1; i >= 0; i--) begin
      if (i < n) begin
        fb = c[CRC_W-1] ^ d[i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_drv_sync.sv
module spi_drv_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_drv_shifter.sv
module spi_drv_shifter #(
  parameter int FW = 24,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [FW-1:0] load_word,
  input  logic [PW-1:0] flen,
  input  logic          rise,
  input  logic          fall,
  input  logic          sdi,
  input  logic          ins_en,
  input  logic [7:0]    ins_data,
  output logic [FW-1:0] sh,
  output logic [PW-1:0] pos,
  output logic [1:0]    nfr,
  output logic          sdo,
  output logic          sdo_oe
);
  logic [PW-1:0] top;
  assign top = flen - PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      pos    <= '0;
      nfr    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (start) begin
      sh     <= load_word;
      pos    <= '0;
      nfr    <= '0;
      sdo    <= load_word[top];
      sdo_oe <= 1'b1;
    end else begin
      if (stop) sdo_oe <= 1'b0;
      if (rise) begin
        sh <= {sh[FW-2:0], sdi};
        if (pos == top) begin
          pos <= '0;
          if (nfr != 2'd3) nfr <= nfr + 2'd1;
        end else begin
          pos <= pos + PW'(1);
        end
      end else if (ins_en) begin
        sh[top -: 8] <= ins_data;
      end
      if (fall) sdo <= sh[top];
    end
  end
endmodule

// File: rtl/spi_drv_regfile.sv
module spi_drv_regfile #(
  parameter int NREG = 8,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_drive_slave.sv
module spi_drive_slave
  import spi_drv_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms0,
  input  logic       ms1,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic [7:0] diag_in,
  input  logic       uv_in,
  input  logic       mv_in,
  input  logic       cf_in,
  output logic [7:0] drive_q,
  output logic       crc_err_n
);
  localparam int RAW  = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int NPIN = 5;

  // pin synchronizers: {ms1, ms0, sdi, sclk, cs_n}
  logic [NPIN-1:0] pin_s;
  spi_drv_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) u_sync (
    .clk(clk), .rst(rst), .d({ms1, ms0, sdi, sclk, cs_n}), .q(pin_s)
  );

  logic cs_s, sclk_s, sdi_s, cs_d, sclk_d;
  logic [1:0] ms_s;
  assign cs_s   = pin_s[0];
  assign sclk_s = pin_s[1];
  assign sdi_s  = pin_s[2];
  assign ms_s   = pin_s[4:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  logic cs_fall, cs_rise, rise_g, fall_g;
  assign cs_fall = cs_d & ~cs_s;
  assign cs_rise = ~cs_d & cs_s;
  assign rise_g  = sclk_s & ~sclk_d & ~cs_s;
  assign fall_g  = ~sclk_s & sclk_d & ~cs_s;

  // mode latched at frame start
  mode_e mode_q, mode_now;
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= M_DRV8;
    else if (cs_fall) mode_q <= mode_e'(ms_s);
  end
  assign mode_now = cs_fall ? mode_e'(ms_s) : mode_q;

  logic [LEN_W-1:0] flen;
  assign flen = frame_bits(mode_now);

  // outgoing word, right aligned so that bit flen-1 leaves first
  logic [2:0]           stat;
  logic [CRC_W-1:0]     stat_crc;
  logic [FRAME_MAX-1:0] load_word;
  assign stat     = {uv_in, mv_in, cf_in};
  assign stat_crc = crc5_calc({13'b0, stat, diag_in}, 11);

  always_comb begin
    case (mode_now)
      M_DRV16: load_word = {8'b0, stat, stat_crc, diag_in};
      M_REG24: load_word = {stat, stat_crc, 8'h00, diag_in};
      default: load_word = {16'b0, diag_in};
    endcase
  end

  logic [FRAME_MAX-1:0] sh;
  logic [LEN_W-1:0]     pos;
  logic [1:0]           nfr;
  logic                 ins_en;
  logic [7:0]           ins_data;

  spi_drv_shifter #(.FW(FRAME_MAX), .PW(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .start(cs_fall), .stop(cs_rise),
    .load_word(load_word), .flen(flen),
    .rise(rise_g), .fall(fall_g), .sdi(sdi_s),
    .ins_en(ins_en), .ins_data(ins_data),
    .sh(sh), .pos(pos), .nfr(nfr), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // read path: address byte complete -> fetch -> patch transmit word
  logic       st1, st2, sel_drv, sel_oor;
  logic [7:0] rf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1     <= 1'b0;
      st2     <= 1'b0;
      sel_drv <= 1'b0;
      sel_oor <= 1'b0;
    end else begin
      st1     <= rise_g & mode_q[1] & (nfr == 2'd0) & (pos == LEN_W'(7));
      st2     <= st1 & ~sh[0];
      sel_drv <= (sh[7:1] == 7'd0);
      sel_oor <= (32'(sh[7:1]) >= NREG);
    end
  end
  assign ins_en   = st2;
  assign ins_data = sel_drv ? drive_q : (sel_oor ? 8'h00 : rf_q);

  // frame decode at chip-select release
  logic       dec_drv, dec_wr, crc_ok;
  logic [6:0] dec_addr;
  logic [7:0] dec_data;

  always_comb begin
    dec_drv  = 1'b0;
    dec_wr   = 1'b0;
    dec_addr = '0;
    dec_data = '0;
    crc_ok   = 1'b1;
    case (mode_q)
      M_DRV8: begin
        dec_drv  = 1'b1;
        dec_data = sh[7:0];
      end
      M_DRV16: begin
        dec_drv  = 1'b1;
        dec_data = sh[15:8];
        crc_ok   = (crc5_calc({13'b0, sh[15:5]}, 11) == sh[4:0]);
      end
      M_REG16: begin
        dec_addr = sh[15:9];
        dec_wr   = sh[8];
        dec_data = sh[7:0];
      end
      default: begin
        dec_addr = sh[23:17];
        dec_wr   = sh[16];
        dec_data = sh[15:8];
        crc_ok   = (crc5_calc({5'b0, sh[23:5]}, 19) == sh[4:0]);
      end
    endcase
  end

  logic frame_ok, commit, drv_we, rf_we;
  assign frame_ok = cs_rise & (pos == '0) & (nfr != 2'd0) & (~mode_q[1] | (nfr == 2'd1));
  assign commit   = frame_ok & crc_ok;
  assign drv_we   = commit & (dec_drv | (dec_wr & (dec_addr == 7'd0)));
  assign rf_we    = commit & ~dec_drv & dec_wr & (dec_addr != 7'd0) & (32'(dec_addr) < NREG);

  spi_drv_regfile #(.NREG(NREG), .AW(RAW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(dec_addr[RAW-1:0]), .wdata(dec_data),
    .raddr(sh[RAW:1]), .rdata(rf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q   <= 8'h00;
      crc_err_n <= 1'b1;
    end else begin
      if (drv_we)   drive_q   <= dec_data;
      if (frame_ok) crc_err_n <= crc_ok;
    end
  end

endmodule

// File: rtl/spi_drv_chk.sv
module spi_drv_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [7:0] drive_q,
  input logic       crc_err_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (drive_q == 8'h00) && crc_err_n && !sdo_oe);

  // R2
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  // R2
  sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> !$past(sclk, 3));

  // R9
  drive_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive_q) |-> cs_n);

  // R6
  crc_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_err_n) |-> cs_n);
endmodule

bind spi_drive_slave spi_drv_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
  .sdo_oe(sdo_oe), .drive_q(drive_q), .crc_err_n(crc_err_n)
);

// File: tb/sim_spi_drive_slave.sv
module sim_spi_drive_slave;
  localparam int HALF = 6;
  localparam int NREG = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms0 = 1'b0, ms1 = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, crc_err_n;
  logic [7:0] diag_in = 8'h00;
  logic       uv_in = 1'b0, mv_in = 1'b0, cf_in = 1'b0;
  logic [7:0] drive_q;

  always #5 clk = ~clk;

  spi_drive_slave #(.NREG(NREG)) u0 (
    .clk(clk), .rst(rst), .ms0(ms0), .ms1(ms1), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .diag_in(diag_in), .uv_in(uv_in),
    .mv_in(mv_in), .cf_in(cf_in), .drive_q(drive_q), .crc_err_n(crc_err_n)
  );

  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;
  logic oe_mid;
  logic [7:0] mdl_drive;
  logic [7:0] mdl_mem [NREG];

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] bcrc5(input logic [23:0] v, input int n);
    logic [4:0] r;
    logic       f;
    r = 5'b11111;
    for (int k = n - 1; k >= 0; k--) begin
      f = r[4] ^ v[k];
      r = {r[3:0], 1'b0} ^ (f ? 5'h05 : 5'h00);
    end
    return r;
  endfunction

  function automatic logic [47:0] enc(input logic [1:0] m, input logic [7:0] d,
                                      input logic [6:0] a, input logic rw);
    logic [23:0] w;
    case (m)
      2'd0: return {40'b0, d};
      2'd1: begin w = {13'b0, d, 3'b000}; return {32'b0, d, 3'b000, bcrc5(w, 11)}; end
      2'd2: return {32'b0, a, rw, d};
      default: begin w = {5'b0, a, rw, d, 3'b000}; return {24'b0, a, rw, d, 3'b000, bcrc5(w, 19)}; end
    endcase
  endfunction

  function automatic logic [47:0] exp_out(input logic [1:0] m, input logic rd, input logic [7:0] val);
    logic [2:0] st;
    logic [4:0] c;
    st = {uv_in, mv_in, cf_in};
    c  = bcrc5({13'b0, st, diag_in}, 11);
    case (m)
      2'd0: return {40'b0, diag_in};
      2'd1: return {32'b0, st, c, diag_in};
      2'd2: return {32'b0, 8'h00, rd ? val : diag_in};
      default: return {24'b0, st, c, rd ? val : 8'h00, diag_in};
    endcase
  endfunction

  function automatic int flen(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd3) ? 24 : 16;
  endfunction

  task automatic frame(input logic [1:0] m, input int n, input logic [47:0] din,
                       input int chg_at, input logic [1:0] m_chg, output logic [47:0] dout);
    dout = '0;
    @(negedge clk);
    {ms1, ms0} = m;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    oe_mid = sdo_oe;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) {ms1, ms0} = m_chg;
      sdi = din[n-1-i];
      repeat (HALF) @(negedge clk);
      dout = {dout[46:0], sdo};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [7:0] mdl_read(input logic [6:0] a);
    if (a == 7'd0) return mdl_drive;
    if (int'(a) < NREG) return mdl_mem[a[2:0]];
    return 8'h00;
  endfunction

  task automatic reg_op(input logic [1:0] m, input logic [6:0] a, input logic rw,
                        input logic [7:0] d, input string tag);
    logic [47:0] dout, exp;
    logic [7:0]  v;
    v   = mdl_read(a);
    exp = exp_out(m, !rw, v);
    frame(m, flen(m), enc(m, rw ? d : 8'h00, a, rw), 999, 2'd0, dout);
    if (rw) begin
      if (a == 7'd0) mdl_drive = d;
      else if (int'(a) < NREG) mdl_mem[a[2:0]] = d;
    end
    chk({tag, " sdo"}, dout, exp);
    chk({tag, " drive"}, {40'b0, drive_q}, {40'b0, mdl_drive});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] dout, din, a16, b16;
    logic [7:0]  d;
    logic [1:0]  m;
    logic [6:0]  a;
    logic        rw;
    void'($urandom(32'd4242));
    mdl_drive = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 drive", {40'b0, drive_q}, 48'h0);
    chk("R1 crc_err_n", {47'b0, crc_err_n}, 48'h1);
    chk("R1 sdo_oe", {47'b0, sdo_oe}, 48'h0);

    // R3 / R2 directed mode 0 frame
    diag_in = 8'hA5;
    frame(2'd0, 8, enc(2'd0, 8'h3C, 7'd0, 1'b0), 999, 2'd0, dout);
    mdl_drive = 8'h3C;
    chk("R3 sdo", dout, exp_out(2'd0, 1'b0, 8'h0));
    chk("R3 drive", {40'b0, drive_q}, 48'h3C);
    chk("R2 oe in frame", {47'b0, oe_mid}, 48'h1);
    chk("R2 oe after frame", {47'b0, sdo_oe}, 48'h0);

    // R4 daisy chain, mode 0, two frames
    diag_in = 8'h5E;
    din = {32'b0, 8'h81, 8'h42};
    frame(2'd0, 16, din, 999, 2'd0, dout);
    mdl_drive = 8'h42;
    chk("R4 sdo mode0", dout, {32'b0, 8'h5E, 8'h81});
    chk("R4 drive mode0", {40'b0, drive_q}, 48'h42);

    // R4 daisy chain, mode 1
    uv_in = 1'b1; cf_in = 1'b1; diag_in = 8'h0F;
    a16 = enc(2'd1, 8'h77, 7'd0, 1'b0);
    b16 = enc(2'd1, 8'hC3, 7'd0, 1'b0);
    frame(2'd1, 32, {a16[15:0], b16[15:0]}, 999, 2'd0, dout);
    mdl_drive = 8'hC3;
    chk("R4 sdo mode1", dout, {16'b0, exp_out(2'd1, 1'b0, 8'h0) << 16} | {32'b0, a16[15:0]});
    chk("R4 drive mode1", {40'b0, drive_q}, 48'hC3);

    // R5 directed mode 1
    frame(2'd1, 16, enc(2'd1, 8'h19, 7'd0, 1'b0), 999, 2'd0, dout);
    mdl_drive = 8'h19;
    chk("R5 sdo", dout, exp_out(2'd1, 1'b0, 8'h0));
    chk("R5 drive", {40'b0, drive_q}, 48'h19);

    // R6 bad checksum in mode 1, then recovery
    din = enc(2'd1, 8'hEE, 7'd0, 1'b0) ^ 48'h1;
    frame(2'd1, 16, din, 999, 2'd0, dout);
    chk("R6 drive kept", {40'b0, drive_q}, {40'b0, mdl_drive});
    chk("R6 flag low", {47'b0, crc_err_n}, 48'h0);
    frame(2'd1, 16, enc(2'd1, 8'h6D, 7'd0, 1'b0), 999, 2'd0, dout);
    mdl_drive = 8'h6D;
    chk("R6 flag cleared", {47'b0, crc_err_n}, 48'h1);

    // R7 fill register file via mode 2, then read back
    uv_in = 1'b0; cf_in = 1'b0;
    for (int k = 1; k < NREG; k++) reg_op(2'd2, 7'(k), 1'b1, 8'(8'h10 * k + k), "R7 write");
    for (int k = 0; k < NREG; k++) reg_op(2'd2, 7'(k), 1'b0, 8'h00, "R7 read");
    reg_op(2'd2, 7'd0, 1'b1, 8'h99, "R7 write drive");

    // R8 mode 3 write and read
    mv_in = 1'b1;
    reg_op(2'd3, 7'd3, 1'b1, 8'hB4, "R8 write");
    reg_op(2'd3, 7'd3, 1'b0, 8'h00, "R8 read");
    reg_op(2'd3, 7'd0, 1'b0, 8'h00, "R8 read drive");

    // R6 bad checksum in mode 3
    din = enc(2'd3, 8'h11, 7'd2, 1'b1) ^ 48'h4;
    frame(2'd3, 24, din, 999, 2'd0, dout);
    chk("R6 flag low mode3", {47'b0, crc_err_n}, 48'h0);
    reg_op(2'd2, 7'd2, 1'b0, 8'h00, "R6 reg kept");
    chk("R6 flag cleared mode2", {47'b0, crc_err_n}, 48'h1);

    // R9 wrong bit counts
    frame(2'd0, 7, 48'h55, 999, 2'd0, dout);
    chk("R9 drive 7 bits", {40'b0, drive_q}, {40'b0, mdl_drive});
    frame(2'd2, 15, {33'b0, enc(2'd2, 8'h44, 7'd4, 1'b1)} >> 1, 999, 2'd0, dout);
    a16 = enc(2'd2, 8'h44, 7'd4, 1'b1);
    frame(2'd2, 32, {a16[15:0], a16[15:0]}, 999, 2'd0, dout);
    reg_op(2'd2, 7'd4, 1'b0, 8'h00, "R9 reg kept");

    // R10 mode pins move mid-frame
    frame(2'd0, 8, 48'hD2, 3, 2'd3, dout);
    mdl_drive = 8'hD2;
    chk("R10 drive", {40'b0, drive_q}, 48'hD2);
    chk("R10 sdo", dout, exp_out(2'd0, 1'b0, 8'h0));

    // R11 out of range
    reg_op(2'd2, 7'd9, 1'b1, 8'hAA, "R11 write");
    reg_op(2'd2, 7'd9, 1'b0, 8'h00, "R11 read");
    reg_op(2'd2, 7'd1, 1'b0, 8'h00, "R11 no alias");

    // random mix
    for (int it = 0; it < 40; it++) begin
      m  = 2'($urandom % 4);
      d  = 8'($urandom);
      a  = 7'($urandom % 10);
      rw = 1'($urandom % 2);
      diag_in = 8'($urandom);
      {uv_in, mv_in, cf_in} = 3'($urandom);
      if (m[1] == 1'b0) begin
        frame(m, flen(m), enc(m, d, 7'd0, 1'b0), 999, 2'd0, dout);
        chk(m[0] ? "R5 rnd sdo" : "R3 rnd sdo", dout, exp_out(m, 1'b0, 8'h0));
        mdl_drive = d;
        chk(m[0] ? "R5 rnd drive" : "R3 rnd drive", {40'b0, drive_q}, {40'b0, d});
      end else begin
        reg_op(m, a, rw, d, m[0] ? "R8 rnd" : "R7 rnd");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule